// File: doc/BRIEF.md
# Interrupt entry, return and tail-chaining sequencer

This block is the control sequencer of a small in-order core that sits between the interrupt requests and the core's exception logic. It watches a set of pending requests, each with its own priority. It compares the best of them against the priority of whatever is running and decides when to leave the running code. Entering a handler means pushing eight context words to a stack port and then requesting the handler address from the vector table. Once that fetch latency has passed, the block pulses a handler-start strobe.

A return is detected when the core loads the program counter with an all-ones value in its upper 28 bits. At a return the block either restores the saved context, or chains straight into a pending request that outranks the context being returned to, without reading the stack at all. A restore that is already running is dropped as soon as such a request appears. A request that outranks the running handler nests on top of it. A depth counter and a small priority stack track which context a return lands in.

Top module: `irq_chain_seq`

## Requirements
- R1: After reset every strobe output is low and `depth_o` is 0.
- R2: Entry happens when the best pending request has a priority number strictly below the running priority. That is `base_prio_i` at depth 0, otherwise the running handler's priority. Entry writes 8 stack words on consecutive cycles, starting in the cycle after the sampling edge. Word index order is 0=xPSR, 1=PC, 2=LR, 3=R12, 4=R3, 5=R2, 6=R1, 7=R0.
- R3: In the cycle after the last stack write, `vec_req_o` pulses with `vec_addr_o` = `VEC_BASE` + 0x40 + 4*N for request N (`VEC_BASE` defaults to 0).
- R4: `hdl_start_o` pulses for one cycle, 12 cycles after the entry's sampling edge, with `hdl_irq_o` = N. At that point `depth_o` has grown by one.
- R5: The winner has the lowest priority number, and a tie goes to the lower request index. A request whose priority number is not strictly below the threshold has no effect.
- R6: A return is recognised only when `pc_load_i` is high, `ret_pc_hi_i` is all ones and `depth_o` is nonzero. Any other PC load, or a return at depth 0, has no effect.
- R7: On a return with no qualifying request, stack words are read on 8 consecutive cycles, index 7 down to 0, starting in the cycle after the return edge. `fg_resume_o` pulses 10 cycles after the return edge, and `depth_o` then drops by one.
- R8: A request qualifies at a return if it beats the context being returned to: the enclosing handler's priority, or `base_prio_i` when returning to depth 0. Such a request chains in with no stack reads. `vec_req_o` pulses in the cycle after the return edge, `hdl_start_o` pulses 6 cycles after that edge, and `depth_o` is unchanged.
- R9: A qualifying request that arrives during a restore stops the reads at once. The vector request follows the sampling edge and `hdl_start_o` comes 6 cycles after it. No `fg_resume_o` pulse is produced, and `depth_o` is unchanged.
- R10: A request that beats the running handler preempts it with a full entry (R2 to R4 timing). Its later return restores to the preempted handler, whose priority then sets the preemption threshold again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pend_i | input | N_IRQ | Pending request lines, held until the handler starts |
| irq_prio_i | input | N_IRQ*PRIO_W | Priority of each request, request i in slice i |
| base_prio_i | input | PRIO_W | Priority of the foreground code |
| pc_load_i | input | 1 | Core is loading the program counter this cycle |
| ret_pc_hi_i | input | ADDR_W-4 | Upper bits of the value being loaded |
| stk_we_o | output | 1 | Stack word write strobe |
| stk_rd_o | output | 1 | Stack word read strobe |
| stk_idx_o | output | log2(NUM_WORDS) | Context word index of the current stack access |
| vec_req_o | output | 1 | Vector table read request |
| vec_addr_o | output | ADDR_W | Vector table address |
| hdl_start_o | output | 1 | First handler instruction may issue |
| hdl_irq_o | output | log2(N_IRQ) | Request being serviced |
| fg_resume_o | output | 1 | Restore finished, interrupted context resumes |
| depth_o | output | log2(MAX_DEPTH+1) | Number of active handlers |

## Verification
Every result is timed from the clock edge that samples the stimulus. Stack writes run at offsets 0 to 7, the vector request comes at offset 8 and the handler start at offset 12 for an entry. For a chain or an abandoned restore, the vector request is at offset 0 and the start at offset 6. A restore reads at offsets 0 to 7 and signals resume at offset 10. When the bench drives a request or a return, it computes these target cycles and queues the expected events. A monitor stamps each observed strobe with a free-running cycle count and requires its kind, cycle and value to match the head of the queue exactly. An extra event, a late one or a missing one is therefore a miscompare. Stimulus that must have no effect is followed by a quiet window and a check of the depth count.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_RUN,
    SEQ_STACK,
    SEQ_FETCH,
    SEQ_UNSTACK
  } seq_state_e;
endpackage

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 3,
  localparam int IRQ_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0]        pend_i,
  input  logic [N_IRQ*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       thresh_i,
  output logic                    hit_o,
  output logic [IRQ_W-1:0]        id_o,
  output logic [PRIO_W-1:0]       prio_o
);
  logic found;

  // strict compare keeps the lower index on a tie
  always_comb begin
    found  = 1'b0;
    id_o   = '0;
    prio_o = '1;
    for (int i = 0; i < N_IRQ; i++) begin
      if (pend_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
        found  = 1'b1;
        id_o   = IRQ_W'(i);
        prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
    hit_o = found && (prio_o < thresh_i);
  end
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
  parameter int PRIO_W    = 3,
  parameter int MAX_DEPTH = 4,
  localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic               repl_i,
  input  logic [PRIO_W-1:0]  prio_i,
  input  logic [PRIO_W-1:0]  base_i,
  output logic [PRIO_W-1:0]  cur_prio_o,
  output logic [PRIO_W-1:0]  ret_prio_o,
  output logic               full_o,
  output logic [DEPTH_W-1:0] depth_o
);
  logic [PRIO_W-1:0]  mem_q [MAX_DEPTH];
  logic [DEPTH_W-1:0] depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < MAX_DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < MAX_DEPTH; i++) begin
        if (push_i && depth_q == DEPTH_W'(i)) mem_q[i] <= prio_i;
        if (repl_i && depth_q == DEPTH_W'(i + 1)) mem_q[i] <= prio_i;
      end
      if (push_i) depth_q <= depth_q + 1'b1;
      else if (pop_i) depth_q <= depth_q - 1'b1;
    end
  end

  // running level and the level a return lands in
  always_comb begin
    cur_prio_o = base_i;
    ret_prio_o = base_i;
    for (int i = 0; i < MAX_DEPTH; i++) begin
      if (depth_q == DEPTH_W'(i + 1)) cur_prio_o = mem_q[i];
      if (depth_q == DEPTH_W'(i + 2)) ret_prio_o = mem_q[i];
    end
  end

  assign full_o  = (depth_q == DEPTH_W'(MAX_DEPTH));
  assign depth_o = depth_q;
endmodule

// File: rtl/irq_chain_seq.sv
module irq_chain_seq
  import irq_seq_pkg::*;
#(
  parameter int N_IRQ       = 8,
  parameter int PRIO_W      = 3,
  parameter int MAX_DEPTH   = 4,
  parameter int ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0,
  parameter int VEC_OFS     = 'h40,
  parameter int NUM_WORDS   = 8,
  parameter int ENTRY_FETCH = 4,
  parameter int CHAIN_FETCH = 6,
  parameter int RESTORE_CYC = 10
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_IRQ-1:0]                 irq_pend_i,
  input  logic [N_IRQ*PRIO_W-1:0]          irq_prio_i,
  input  logic [PRIO_W-1:0]                base_prio_i,
  input  logic                             pc_load_i,
  input  logic [ADDR_W-5:0]                ret_pc_hi_i,
  output logic                             stk_we_o,
  output logic                             stk_rd_o,
  output logic [$clog2(NUM_WORDS)-1:0]     stk_idx_o,
  output logic                             vec_req_o,
  output logic [ADDR_W-1:0]                vec_addr_o,
  output logic                             hdl_start_o,
  output logic [$clog2(N_IRQ)-1:0]         hdl_irq_o,
  output logic                             fg_resume_o,
  output logic [$clog2(MAX_DEPTH+1)-1:0]   depth_o
);
  localparam int IRQ_W   = $clog2(N_IRQ);
  localparam int IDX_W   = $clog2(NUM_WORDS);
  localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);
  localparam int CNT_W   = $clog2(NUM_WORDS + ENTRY_FETCH + CHAIN_FETCH + RESTORE_CYC);

  seq_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, flen_q, flen_d;
  logic [IRQ_W-1:0]   sel_q, sel_d;
  logic               start_q, start_d, resume_q, resume_d;

  logic               arb_hit;
  logic [IRQ_W-1:0]   arb_id;
  logic [PRIO_W-1:0]  arb_prio, thresh, cur_prio, ret_prio;
  logic               push, pop, repl, full, ret_ev;

  assign ret_ev = (state_q == SEQ_RUN) && pc_load_i && (&ret_pc_hi_i) && (depth_o != '0);
  // a return or a restore compares against the context being returned to
  assign thresh = (state_q == SEQ_RUN && !ret_ev) ? cur_prio : ret_prio;

  irq_arb #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) arb_i (
    .pend_i   (irq_pend_i),
    .prio_i   (irq_prio_i),
    .thresh_i (thresh),
    .hit_o    (arb_hit),
    .id_o     (arb_id),
    .prio_o   (arb_prio)
  );

  irq_prio_stack #(.PRIO_W(PRIO_W), .MAX_DEPTH(MAX_DEPTH)) pstk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .repl_i     (repl),
    .prio_i     (arb_prio),
    .base_i     (base_prio_i),
    .cur_prio_o (cur_prio),
    .ret_prio_o (ret_prio),
    .full_o     (full),
    .depth_o    (depth_o)
  );

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    flen_d   = flen_q;
    sel_d    = sel_q;
    start_d  = 1'b0;
    resume_d = 1'b0;
    push     = 1'b0;
    pop      = 1'b0;
    repl     = 1'b0;
    unique case (state_q)
      SEQ_RUN: begin
        if (ret_ev) begin
          cnt_d = '0;
          if (arb_hit) begin
            state_d = SEQ_FETCH;
            flen_d  = CNT_W'(CHAIN_FETCH);
            sel_d   = arb_id;
            repl    = 1'b1;
          end else begin
            state_d = SEQ_UNSTACK;
          end
        end else if (arb_hit && !full) begin
          state_d = SEQ_STACK;
          cnt_d   = '0;
          sel_d   = arb_id;
          push    = 1'b1;
        end
      end
      SEQ_STACK: begin
        if (cnt_q == CNT_W'(NUM_WORDS - 1)) begin
          state_d = SEQ_FETCH;
          cnt_d   = '0;
          flen_d  = CNT_W'(ENTRY_FETCH);
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_FETCH: begin
        if (cnt_q == flen_q - 1'b1) begin
          state_d = SEQ_RUN;
          start_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_UNSTACK: begin
        if (arb_hit) begin
          state_d = SEQ_FETCH;
          cnt_d   = '0;
          flen_d  = CNT_W'(CHAIN_FETCH);
          sel_d   = arb_id;
          repl    = 1'b1;
        end else if (cnt_q == CNT_W'(RESTORE_CYC - 1)) begin
          state_d  = SEQ_RUN;
          resume_d = 1'b1;
          pop      = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_RUN;
      cnt_q    <= '0;
      flen_q   <= '0;
      sel_q    <= '0;
      start_q  <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      flen_q   <= flen_d;
      sel_q    <= sel_d;
      start_q  <= start_d;
      resume_q <= resume_d;
    end
  end

  assign stk_we_o    = (state_q == SEQ_STACK);
  assign stk_rd_o    = (state_q == SEQ_UNSTACK) && (cnt_q < CNT_W'(NUM_WORDS));
  assign stk_idx_o   = (state_q == SEQ_STACK) ? cnt_q[IDX_W-1:0]
                                              : IDX_W'(NUM_WORDS - 1) - cnt_q[IDX_W-1:0];
  assign vec_req_o   = (state_q == SEQ_FETCH) && (cnt_q == '0);
  assign vec_addr_o  = VEC_BASE + ADDR_W'(VEC_OFS) + (ADDR_W'(sel_q) << 2);
  assign hdl_start_o = start_q;
  assign hdl_irq_o   = sel_q;
  assign fg_resume_o = resume_q;
endmodule

module irq_chain_seq_chk #(
  parameter int IDX_W   = 3,
  parameter int DEPTH_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               stk_we_o,
  input logic               stk_rd_o,
  input logic [IDX_W-1:0]   stk_idx_o,
  input logic               vec_req_o,
  input logic               hdl_start_o,
  input logic               fg_resume_o,
  input logic [DEPTH_W-1:0] depth_o
);
  // R2
  push_starts_xpsr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stk_we_o) |-> stk_idx_o == '0);
  // R3
  vec_after_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stk_we_o) |-> vec_req_o);
  // R4
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdl_start_o |=> !hdl_start_o);
  // R4
  start_has_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdl_start_o |-> depth_o != '0);
  // R6
  read_needs_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_rd_o |-> depth_o != '0);
  // R7
  pop_descends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_rd_o && $past(stk_rd_o) |-> stk_idx_o == IDX_W'($past(stk_idx_o) - 1'b1));
  // R7
  resume_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fg_resume_o |-> $past(stk_rd_o, 3) && !$past(stk_rd_o, 1));
  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stk_we_o, stk_rd_o, vec_req_o, hdl_start_o, fg_resume_o}));
endmodule

bind irq_chain_seq irq_chain_seq_chk #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stk_we_o    (stk_we_o),
  .stk_rd_o    (stk_rd_o),
  .stk_idx_o   (stk_idx_o),
  .vec_req_o   (vec_req_o),
  .hdl_start_o (hdl_start_o),
  .fg_resume_o (fg_resume_o),
  .depth_o     (depth_o)
);

// File: tb/irq_chain_seq_tb_top.sv
`timescale 1ns/1ps
module irq_chain_seq_tb_top;
  localparam int K_SW = 0, K_VEC = 1, K_HS = 2, K_SR = 3, K_RES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_pend = '0;
  logic [23:0] irq_prio = '0;
  logic [2:0]  base_prio = 3'd7;
  logic        pc_load = 1'b0;
  logic [27:0] pc_hi = '0;
  logic        stk_we, stk_rd, vec_req, hdl_start, fg_resume;
  logic [2:0]  stk_idx, hdl_irq, depth;
  logic [31:0] vec_addr;

  int cyc = 0;
  int n_vec = 0;
  int n_miss = 0;
  bit done = 1'b0;
  int    eq_kind[$];
  int    eq_cyc[$];
  int    eq_val[$];
  string eq_req[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_chain_seq dut_i (
    .clk_i (clk), .rst_ni (rst_n), .irq_pend_i (irq_pend), .irq_prio_i (irq_prio),
    .base_prio_i (base_prio), .pc_load_i (pc_load), .ret_pc_hi_i (pc_hi),
    .stk_we_o (stk_we), .stk_rd_o (stk_rd), .stk_idx_o (stk_idx),
    .vec_req_o (vec_req), .vec_addr_o (vec_addr), .hdl_start_o (hdl_start),
    .hdl_irq_o (hdl_irq), .fg_resume_o (fg_resume), .depth_o (depth)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_miss++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_exp(input int k, input int c, input int v, input string req);
    eq_kind.push_back(k); eq_cyc.push_back(c); eq_val.push_back(v); eq_req.push_back(req);
  endtask

  task automatic ev(input int k, input int v);
    n_vec++;
    if (eq_kind.size() == 0) begin
      n_miss++;
      $display("FAIL R5/R6: unexpected event kind %0d value 0x%0h at cycle %0d, expected none",
               k, v, cyc);
    end else begin
      int ek = eq_kind.pop_front();
      int ec = eq_cyc.pop_front();
      int evv = eq_val.pop_front();
      string er = eq_req.pop_front();
      if (ek != k || ec != cyc || evv != v) begin
        n_miss++;
        $display("FAIL %s: actual kind %0d cycle %0d value 0x%0h, expected kind %0d cycle %0d value 0x%0h",
                 er, k, cyc, v, ek, ec, evv);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (stk_we)    ev(K_SW, int'(stk_idx));
      if (stk_rd)    ev(K_SR, int'(stk_idx));
      if (vec_req)   ev(K_VEC, int'(vec_addr));
      if (hdl_start) ev(K_HS, int'(hdl_irq));
      if (fg_resume) ev(K_RES, int'(depth));
    end
  end

  task automatic exp_entry(input int c0, input int irq);
    for (int i = 0; i < 8; i++) push_exp(K_SW, c0 + i, i, "R2");
    push_exp(K_VEC, c0 + 8, 'h40 + 4 * irq, "R3");
    push_exp(K_HS, c0 + 12, irq, "R4");
  endtask

  task automatic exp_restore(input int r0, input int dep_after);
    for (int i = 0; i < 8; i++) push_exp(K_SR, r0 + i, 7 - i, "R7");
    push_exp(K_RES, r0 + 10, dep_after, "R7");
  endtask

  task automatic exp_chain(input int r0, input int irq, input string req);
    push_exp(K_VEC, r0, 'h40 + 4 * irq, req);
    push_exp(K_HS, r0 + 6, irq, req);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic raise(input int irq, input int pr);
    irq_prio[irq*3 +: 3] = 3'(pr);
    irq_pend[irq] = 1'b1;
  endtask

  task automatic do_ret(output int r);
    pc_load = 1'b1;
    pc_hi = '1;
    r = cyc + 1;
    @(negedge clk);
    pc_load = 1'b0;
    pc_hi = '0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_vec++;
      n_miss++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    int c0, c1, r0, r1;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk({stk_we, stk_rd, vec_req, hdl_start, fg_resume} == 5'b0, "R1",
        int'({stk_we, stk_rd, vec_req, hdl_start, fg_resume}), 0);
    chk(depth == 3'd0, "R1", int'(depth), 0);

    // single entry and full restore
    raise(3, 4);
    c0 = cyc + 1;
    exp_entry(c0, 3);
    wait_until(c0 + 12);
    irq_pend[3] = 1'b0;
    chk(depth == 3'd1, "R4", int'(depth), 1);
    tick(2);
    // R6 ordinary PC load is not a return
    pc_load = 1'b1; pc_hi = 28'h0000100;
    tick(1);
    pc_load = 1'b0; pc_hi = '0;
    tick(15);
    chk(depth == 3'd1, "R6", int'(depth), 1);
    do_ret(r0);
    exp_restore(r0, 0);
    wait_until(r0 + 10);
    chk(depth == 3'd0, "R7", int'(depth), 0);
    tick(2);
    // R6 return at depth 0 ignored
    do_ret(r0);
    tick(14);
    chk(depth == 3'd0, "R6", int'(depth), 0);

    // R5 request not below base is masked
    base_prio = 3'd5;
    raise(4, 5);
    tick(20);
    chk(depth == 3'd0, "R5", int'(depth), 0);
    irq_pend[4] = 1'b0;
    base_prio = 3'd7;
    tick(1);

    // R5 tie broken by lower index
    raise(5, 1);
    raise(2, 1);
    c0 = cyc + 1;
    exp_entry(c0, 2);
    wait_until(c0 + 12);
    irq_pend[2] = 1'b0;
    chk(hdl_irq == 3'd2, "R5", int'(hdl_irq), 2);
    tick(3);
    chk(depth == 3'd1, "R5", int'(depth), 1);

    // R8 tail chain into request 5
    do_ret(r0);
    exp_chain(r0, 5, "R8");
    wait_until(r0 + 6);
    irq_pend[5] = 1'b0;
    chk(depth == 3'd1, "R8", int'(depth), 1);
    tick(2);
    do_ret(r1);
    exp_restore(r1, 0);
    wait_until(r1 + 10);
    tick(2);

    // R10 nesting
    raise(1, 3);
    c0 = cyc + 1;
    exp_entry(c0, 1);
    wait_until(c0 + 12);
    irq_pend[1] = 1'b0;
    tick(2);
    raise(0, 1);
    c1 = cyc + 1;
    exp_entry(c1, 0);
    wait_until(c1 + 12);
    irq_pend[0] = 1'b0;
    chk(depth == 3'd2, "R10", int'(depth), 2);
    raise(6, 4);
    tick(2);
    do_ret(r0);
    exp_restore(r0, 1);
    wait_until(r0 + 10);
    chk(depth == 3'd1, "R10", int'(depth), 1);
    tick(3);
    chk(depth == 3'd1, "R10", int'(depth), 1);
    // R8 return to foreground lets request 6 chain in
    do_ret(r1);
    exp_chain(r1, 6, "R8");
    wait_until(r1 + 6);
    irq_pend[6] = 1'b0;
    chk(depth == 3'd1, "R8", int'(depth), 1);
    tick(2);

    // R9 abandoned restore
    do_ret(r0);
    for (int i = 0; i < 3; i++) push_exp(K_SR, r0 + i, 7 - i, "R9");
    exp_chain(r0 + 3, 7, "R9");
    wait_until(r0 + 2);
    raise(7, 2);
    wait_until(r0 + 9);
    irq_pend[7] = 1'b0;
    chk(depth == 3'd1, "R9", int'(depth), 1);
    tick(2);
    do_ret(r1);
    exp_restore(r1, 0);
    wait_until(r1 + 10);
    chk(depth == 3'd0, "R7", int'(depth), 0);
    tick(5);
    chk(eq_kind.size() == 0, "R2/R7", eq_kind.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule